// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter on a simple register write port. Once enabled, it counts clock ticks. If software lets the count reach the selected limit, the block drives a fixed-length system reset pulse. Software holds the reset off by writing a two-word service pattern.

Every write that changes state must be authorised. Writing a 32-bit key to the unlock register grants exactly one protected write, which may go to the control register or to the service register. The control register holds three fields:

- an enable bit;
- a bit that inserts a power-of-two pre-divider ahead of the counter;
- a 4-bit exponent n that sets the limit to 2^(BASE_LOG+n) ticks.

The control register reads back, so software can read, modify and write it. A protected control write also clears the counter and the pre-divider. A newly chosen timeout therefore always starts from zero.

Top module: `key_watchdog`

## Requirements
- R1: After reset the control register reads 0 (disabled, pre-divider off, n = 0) and `wdt_rst_o` is low.
- R2: Register addresses are 0 = unlock, 1 = control, 2 = service; address 3 holds no register. Writing `UNLOCK_KEY` (default 0x6F70746B) to address 0 grants one protected write. Any other write (a wrong key, or any other address) removes the permission, and the protected write consumes it.
- R3: A control write made without permission leaves the control register unchanged.
- R4: The control fields are bit 0 = enable, bit 1 = pre-divider on, bits 5:2 = n. When `addr` is 1, `rdata[5:0]` shows the register in the same cycle and `rdata[31:6]` is zero.
- R5: While enabled, `wdt_rst_o` rises exactly 2^(BASE_LOG+n) cycles after the clock edge of the restarting write. With the pre-divider on, this becomes 2^(BASE_LOG+n+PRE_LOG) cycles.
- R6: With bit 0 clear the counter is stopped and no reset pulse is produced.
- R7: On timeout, `wdt_rst_o` stays high for exactly `PULSE_LEN` cycles (default 16). The count restarts from zero at the same edge.
- R8: A protected write of `SVC_WORD0` (default 0x55AA9BDF) to the service register, followed by a protected write of `SVC_WORD1` (default 0x1357AA55) to it, restarts the counter and the pre-divider at the edge of the second write.
- R9: Any other service write breaks the pattern and restarts nothing. This covers a wrong word, the second word alone, and a second word written without its own unlock.
- R10: A protected control write restarts the counter and the pre-divider at its edge, including a rewrite of the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Control readback while `addr` is 1, else zero |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
Readback is combinational, so it is checked in the cycle after a write's edge with `addr` held at 1. The timeout is measured against a free-running cycle counter. The reference point is the edge that carried the restarting write, whether that was a control write or the second service word. The bench expects `wdt_rst_o` to be seen high first at exactly that edge plus 2^(BASE_LOG+n), or that plus PRE_LOG more powers of two with the pre-divider on. Pulse width is counted in cycles from the rise. All sampling is done on the falling edge, so each result is read one half-cycle after the edge that produced it.

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter logic [31:0] UNLOCK_KEY = 32'h6F70746B,
  parameter logic [31:0] SVC_WORD0  = 32'h55AA9BDF,
  parameter logic [31:0] SVC_WORD1  = 32'h1357AA55,
  parameter int BASE_LOG  = 10,
  parameter int PRE_LOG   = 10,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wdt_rst_o
);
  localparam int CW = BASE_LOG + 16;
  localparam int RW = $clog2(PULSE_LEN + 1);
  localparam logic [1:0] A_KEY = 2'd0, A_CTRL = 2'd1, A_SVC = 2'd2;

  logic [5:0]         ctrl;
  logic               unlocked, svc_armed;
  logic [CW-1:0]      cnt, last;
  logic [PRE_LOG-1:0] pre;
  logic [RW-1:0]      rst_cnt;

  wire       en     = ctrl[0];
  wire       pre_on = ctrl[1];
  wire [3:0] n      = ctrl[5:2];

  wire wr_key  = wr_en && addr == A_KEY && wdata == UNLOCK_KEY;
  wire wr_ctrl = wr_en && addr == A_CTRL && unlocked;
  wire wr_svc  = wr_en && addr == A_SVC;
  wire kick    = wr_svc && unlocked && svc_armed && wdata == SVC_WORD1;
  wire restart = wr_ctrl || kick;
  wire tick    = !pre_on || pre == '1;

  always_comb last = (CW'(1) << (BASE_LOG + int'(n))) - CW'(1);

  wire expire = en && tick && cnt == last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      unlocked  <= 1'b0;
      svc_armed <= 1'b0;
      cnt       <= '0;
      pre       <= '0;
      rst_cnt   <= '0;
    end else begin
      if (wr_en) unlocked <= wr_key;
      if (wr_ctrl) ctrl <= wdata[5:0];
      if (wr_svc) svc_armed <= unlocked && wdata == SVC_WORD0;

      if (restart) pre <= '0;
      else if (en && pre_on) pre <= pre + 1'b1;

      if (restart || expire) cnt <= '0;
      else if (en && tick) cnt <= cnt + 1'b1;

      if (expire) rst_cnt <= RW'(PULSE_LEN);
      else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign wdt_rst_o = rst_cnt != '0;
  assign rdata     = (addr == A_CTRL) ? {26'b0, ctrl} : 32'b0;
endmodule

// File: rtl/key_watchdog_chk.sv
module key_watchdog_chk #(
  parameter logic [31:0] KEY = 32'h6F70746B,
  parameter int PULSE_LEN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        wdt_rst_o,
  input logic        unlocked,
  input logic [5:0]  ctrl
);
  int hi_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_run <= 0;
    else hi_run <= wdt_rst_o ? hi_run + 1 : 0;

  p_unlock_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !(addr == 2'd0 && wdata == KEY) |=> !unlocked);

  p_ctrl_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd1 && !unlocked |=> $stable(ctrl));

  p_readback_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:6] == 26'b0);

  p_rst_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(ctrl[0]));

  p_pulse_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= PULSE_LEN);

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> hi_run == PULSE_LEN);
endmodule

bind key_watchdog key_watchdog_chk #(.KEY(UNLOCK_KEY), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .wdt_rst_o(wdt_rst_o), .unlocked(unlocked), .ctrl(ctrl));

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  localparam int BASE = 5, PRE = 2, PULSE = 16;
  localparam logic [31:0] KEY = 32'h6F70746B, S0 = 32'h55AA9BDF, S1 = 32'h1357AA55;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [31:0] wdata = '0, rdata;
  logic wdt_rst_o;
  int cyc = 0, checks = 0, errors = 0;

  key_watchdog #(.BASE_LOG(BASE), .PRE_LOG(PRE), .PULSE_LEN(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wdt_rst_o(wdt_rst_o));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1;
  endtask

  task automatic set_ctrl(input int v);
    wr(2'd0, KEY); wr(2'd1, 32'(v));
  endtask

  task automatic service();
    wr(2'd0, KEY); wr(2'd2, S0); wr(2'd0, KEY); wr(2'd2, S1);
  endtask

  task automatic idle(input int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (wdt_rst_o) seen = 1;
    end
  endtask

  task automatic measure(input int start, input int limit, output int d);
    d = -1;
    while (cyc - start < limit) begin
      @(negedge clk);
      if (wdt_rst_o) begin d = cyc - start; break; end
    end
  endtask

  task automatic width(output int w);
    w = 0;
    while (wdt_rst_o) begin w++; @(negedge clk); end
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, w, s, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ctrl", int'(rdata), 0);
    chk("R1 rst", int'(wdt_rst_o), 0);

    // R3: unprotected control write ignored
    wr(2'd1, 32'h1);
    chk("R3 readback", int'(rdata), 0);
    idle(100, s); chk("R3 no reset", s, 0);

    // R2: wrong key, stray write, and consumption
    wr(2'd0, KEY ^ 32'h1); wr(2'd1, 32'h1);
    chk("R2 wrong key", int'(rdata), 0);
    wr(2'd0, KEY); wr(2'd3, 32'h0); wr(2'd1, 32'h1);
    chk("R2 stray write", int'(rdata), 0);
    set_ctrl(32'h8); wr(2'd1, 32'h3C);
    chk("R2 consumed", int'(rdata), 32'h8);
    addr = 2'd0; #1;
    chk("R4 other addr reads zero", int'(rdata), 0);
    addr = 2'd1;

    // R4 R5 R7: sweep n, pre-divider off and on
    for (int pe = 0; pe < 2; pe++) begin
      for (int n = 0; n < (pe ? 4 : 7); n++) begin
        int v, lim;
        v = (n << 2) | (pe << 1) | 1;
        lim = 1 << (BASE + n + (pe ? PRE : 0));
        set_ctrl(v);
        e0 = cyc;
        chk("R4 readback", int'(rdata), v);
        measure(e0, lim + 10, d);
        chk($sformatf("R5 timeout n=%0d pre=%0d", n, pe), d, lim);
        width(w);
        chk("R7 pulse width", w, PULSE);
        if (n == 0 && pe == 0) begin
          measure(e0, 2 * lim + 10, d);
          chk("R7 count restarts", d, 2 * lim);
          width(w);
        end
        set_ctrl(0);
      end
    end

    // R6: disable stops the counter
    set_ctrl(32'h1); idle(10, s); set_ctrl(32'h0);
    idle(300, s);
    chk("R6 no reset when disabled", s, 0);
    chk("R6 readback", int'(rdata), 0);

    // R8: correct service restarts
    set_ctrl(32'h5); idle(40, s); service();
    e0 = cyc;
    measure(e0, 200, d);
    chk("R8 restart from second word", d, 64);
    width(w); set_ctrl(0);
    set_ctrl(32'h1);
    s = 0;
    for (int i = 0; i < 10; i++) begin
      int t;
      idle(20, t); s |= t; service();
      if (wdt_rst_o) s = 1;
    end
    chk("R8 periodic service holds off", s, 0);
    set_ctrl(0);

    // R9: broken sequences do not restart
    for (int c = 0; c < 4; c++) begin
      set_ctrl(32'h5);
      e0 = cyc;
      idle(10, s);
      case (c)
        0: begin wr(2'd0, KEY); wr(2'd2, S1); end
        1: begin wr(2'd0, KEY); wr(2'd2, S0); wr(2'd0, KEY); wr(2'd2, 32'hDEAD);
                 wr(2'd0, KEY); wr(2'd2, S1); end
        2: begin wr(2'd0, KEY); wr(2'd2, S0); wr(2'd2, S1); wr(2'd0, KEY); wr(2'd2, S1); end
        default: begin wr(2'd0, KEY); wr(2'd2, S1); wr(2'd0, KEY); wr(2'd2, S0); end
      endcase
      measure(e0, 200, d);
      chk($sformatf("R9 no restart case %0d", c), d, 64);
      width(w); set_ctrl(0);
    end

    // R10: control rewrite restarts
    set_ctrl(32'h9); idle(60, s); set_ctrl(32'h9);
    e0 = cyc;
    measure(e0, 300, d);
    chk("R10 same value restart", d, 128);
    width(w);
    set_ctrl(32'h9); idle(60, s); set_ctrl(32'h1);
    e0 = cyc;
    measure(e0, 300, d);
    chk("R10 new timeout restart", d, 32);
    width(w); set_ctrl(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule